// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block runs the short relative branch instructions of an 8-bit accumulator processor. A caller presents an opcode byte, a signed 8-bit displacement, the current 16-bit program counter, the stack pointer, the condition flags and the external interrupt pin. It then pulses `start`.

The unit classifies the opcode and evaluates its condition. It reports whether the branch is taken, the next program counter and the instruction's cycle count. The condition tests cover unsigned carry and zero tests, sign tests, signed less-than tests, the interrupt mask and the level of the interrupt pin.

For the subroutine branch, the unit stores the return address on the stack one byte per cycle through a byte-wide write port, and moves the stack pointer down by two. The interrupt pin is resynchronised before it is tested. A `busy`/`done` handshake frames every operation. Opcodes outside the group complete at once and raise `unsupported`.

Top module: `branch_unit`

## Requirements
- R1: While reset is held and right after it, `busy`, `done` and `memWe` are 0 and `pcOut` and `spOut` are 0.
- R2: When an operation completes, `pcOut` is pcIn+2 for a branch not taken, and pcIn+2+sext(rel) modulo 65536 for a branch taken. The displacement `rel` is sign-extended from bit 7.
- R3: Opcode 0x20 is always taken and opcode 0x21 is never taken, whatever the flags.
- R4: The carry and zero tests use flag bits C=`ccr[0]` and Z=`ccr[1]`. Opcode 0x24 is taken when C=0 and 0x25 when C=1. Opcode 0x23 is taken when C|Z=1 and 0x26 when Z=0.
- R5: The sign and mask tests use flag bits N=`ccr[2]` and I=`ccr[3]`. Opcode 0x2A is taken when N=0 and 0x2B when N=1. Opcode 0x2C is taken when I=0 and 0x2D when I=1.
- R6: Opcode 0x2E is taken when the pin is low and 0x2F when it is high. The pin passes through two flops, so the test at a `start` edge sees the pin level from two or more edges earlier. A change made one cycle before `start` is not yet visible.
- R7: The signed tests use V=`ccr[5]`. Opcode 0x91 is taken when N^V=1 and 0x93 when Z|(N^V)=1. H=`ccr[4]` affects no outcome.
- R8: A conditional branch keeps `busy` high for 2 cycles, then raises `done` for one cycle with `cycles`=3. It makes no memory write.
- R9: Opcode 0xAD writes two bytes. The low byte of pcIn+2 goes to address spIn in the first busy cycle. The high byte goes to spIn-1 in the second. The operation ends with `spOut`=spIn-2, `pcOut`=pcIn+2+sext(rel), `taken`=1 and `cycles`=4, after 3 busy cycles.
- R10: Any other opcode raises `done` in the next cycle with `unsupported`=1, `taken`=0, `cycles`=0 and `pcOut`=pcIn. It makes no write.
- R11: A `start` pulse while `busy` is high is ignored. The running operation's results and writes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| opcode | input | 8 | Opcode byte |
| rel | input | 8 | Signed displacement |
| pcIn | input | 16 | Program counter of the instruction |
| spIn | input | 16 | Stack pointer before the instruction |
| ccr | input | 6 | Flags {V,H,I,N,Z,C}, bit 5 down to bit 0 |
| irqPin | input | 1 | Asynchronous interrupt pin level |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken |
| unsupported | output | 1 | Opcode outside the group |
| cycles | output | 3 | Instruction cycle count |
| pcOut | output | 16 | Next program counter |
| spOut | output | 16 | Stack pointer after the instruction |
| memWe | output | 1 | Stack byte write strobe |
| memAddr | output | 16 | Stack write address |
| memData | output | 8 | Stack write data |

## Verification
The assertions assume that `start` is only used as a pulse and that the caller keeps the inputs stable while presenting them. They also assume that `spIn` does not wrap during a push, so the stack pointer steps down by exactly one per write. The bench drives every `start` on a falling edge and releases it one cycle later, apart from the deliberate pulse during `busy`. It holds the interrupt pin steady for three cycles before each random operation, so the synchronised level equals the driven one.

// File: rtl/branch_pkg.sv
package branch_pkg;
  typedef enum logic [1:0] {CLS_NONE, CLS_COND, CLS_SUB} opClass_t;

  typedef struct packed {
    logic load;
    logic pushLo;
    logic pushHi;
    logic applyRel;
  } dpCtrl_t;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_I = 3;
  localparam int FLAG_V = 5;
  localparam int FLAG_W = 6;
endpackage

// File: rtl/branch_decode.sv
module branch_decode
  import branch_pkg::*;
(
  input  logic [7:0]        opcode,
  input  logic [FLAG_W-1:0] ccr,
  input  logic              pinLevel,
  output opClass_t          opClass,
  output logic              takeIt
);
  logic fc, fz, fn, fi, fv, signedLt;

  always_comb begin
    fc = ccr[FLAG_C];
    fz = ccr[FLAG_Z];
    fn = ccr[FLAG_N];
    fi = ccr[FLAG_I];
    fv = ccr[FLAG_V];
    signedLt = fn ^ fv;
    opClass = CLS_COND;
    takeIt = 1'b0;
    case (opcode)
      8'h20: takeIt = 1'b1;
      8'h21: takeIt = 1'b0;
      8'h23: takeIt = fc | fz;
      8'h24: takeIt = ~fc;
      8'h25: takeIt = fc;
      8'h26: takeIt = ~fz;
      8'h2A: takeIt = ~fn;
      8'h2B: takeIt = fn;
      8'h2C: takeIt = ~fi;
      8'h2D: takeIt = fi;
      8'h2E: takeIt = ~pinLevel;
      8'h2F: takeIt = pinLevel;
      8'h91: takeIt = signedLt;
      8'h93: takeIt = fz | signedLt;
      8'hAD: begin opClass = CLS_SUB; takeIt = 1'b1; end
      default: opClass = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_pkg::*;
#(
  parameter int COND_CYCLES = 3,
  parameter int SUB_CYCLES  = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  opClass_t opClass,
  output dpCtrl_t  ctrl,
  output logic     memWe,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = $clog2(SUB_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;
  state_t          state;
  logic [CNT_W-1:0] remain;
  logic            isSub;

  always_comb begin
    busy = (state == ST_RUN);
    done = (state == ST_FIN);
    ctrl.load     = start && !busy;
    ctrl.pushLo   = busy && isSub && (remain == CNT_W'(SUB_CYCLES - 1));
    ctrl.pushHi   = busy && isSub && (remain == CNT_W'(SUB_CYCLES - 2));
    ctrl.applyRel = busy && (remain == CNT_W'(1));
    memWe = ctrl.pushLo | ctrl.pushHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
      isSub  <= 1'b0;
    end else if (ctrl.load) begin
      isSub <= (opClass == CLS_SUB);
      case (opClass)
        CLS_SUB:  begin state <= ST_RUN; remain <= CNT_W'(SUB_CYCLES - 1);  end
        CLS_COND: begin state <= ST_RUN; remain <= CNT_W'(COND_CYCLES - 1); end
        default:  begin state <= ST_FIN; remain <= '0; end
      endcase
    end else if (busy) begin
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) state <= ST_FIN;
    end else if (state == ST_FIN) begin
      state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/branch_datapath.sv
module branch_datapath
  import branch_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int COND_CYCLES = 3,
  parameter int SUB_CYCLES  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctrl,
  input  opClass_t              opClass,
  input  logic                  takeIt,
  input  logic [2*DATA_W-1:0]   pcIn,
  input  logic [2*DATA_W-1:0]   spIn,
  input  logic [DATA_W-1:0]     rel,
  input  logic                  irqPin,
  output logic                  pinLevel,
  output logic [2*DATA_W-1:0]   pcOut,
  output logic [2*DATA_W-1:0]   spOut,
  output logic                  taken,
  output logic                  unsupported,
  output logic [2:0]            cycles,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]     memData
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] pinSync;
  logic [DATA_W-1:0]      relReg;
  logic [ADDR_W-1:0]      relExt;

  assign pinLevel = pinSync[SYNC_STAGES-1];
  assign relExt   = {{(ADDR_W-DATA_W){relReg[DATA_W-1]}}, relReg};
  assign memAddr  = spOut;
  assign memData  = ctrl.pushHi ? pcOut[ADDR_W-1:DATA_W] : pcOut[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) pinSync <= '0;
    else       pinSync <= {pinSync[SYNC_STAGES-2:0], irqPin};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut       <= '0;
      spOut       <= '0;
      relReg      <= '0;
      taken       <= 1'b0;
      unsupported <= 1'b0;
      cycles      <= '0;
    end else if (ctrl.load) begin
      spOut       <= spIn;
      relReg      <= rel;
      unsupported <= (opClass == CLS_NONE);
      taken       <= takeIt && (opClass != CLS_NONE);
      pcOut       <= (opClass == CLS_NONE) ? pcIn : pcIn + ADDR_W'(2);
      case (opClass)
        CLS_SUB:  cycles <= 3'(SUB_CYCLES);
        CLS_COND: cycles <= 3'(COND_CYCLES);
        default:  cycles <= '0;
      endcase
    end else begin
      if (ctrl.pushLo || ctrl.pushHi) spOut <= spOut - 1'b1;
      if (ctrl.applyRel && taken)     pcOut <= pcOut + relExt;
    end
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  rel,
  input  logic [15:0] pcIn,
  input  logic [15:0] spIn,
  input  logic [5:0]  ccr,
  input  logic        irqPin,
  output logic        busy,
  output logic        done,
  output logic        taken,
  output logic        unsupported,
  output logic [2:0]  cycles,
  output logic [15:0] pcOut,
  output logic [15:0] spOut,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [7:0]  memData
);
  opClass_t opClass;
  logic     takeIt;
  logic     pinLevel;
  dpCtrl_t  ctrl;

  branch_decode u_decode (
    .opcode(opcode), .ccr(ccr), .pinLevel(pinLevel),
    .opClass(opClass), .takeIt(takeIt)
  );

  branch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opClass(opClass),
    .ctrl(ctrl), .memWe(memWe), .busy(busy), .done(done)
  );

  branch_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opClass(opClass), .takeIt(takeIt),
    .pcIn(pcIn), .spIn(spIn), .rel(rel), .irqPin(irqPin),
    .pinLevel(pinLevel), .pcOut(pcOut), .spOut(spOut), .taken(taken),
    .unsupported(unsupported), .cycles(cycles),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        taken,
  input logic        unsupported,
  input logic [2:0]  cycles,
  input logic [15:0] spOut,
  input logic        memWe,
  input logic [15:0] memAddr
);
  // R8: busy and done never overlap
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8: done is a single-cycle pulse unless a new start arrives
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> !done);

  // R9: writes only happen inside a busy window
  p_write_in_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R9: each write steps the stack pointer down by one
  p_sp_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> spOut == $past(memAddr) - 16'd1);

  // R10: an unsupported completion reports no branch and no cycles
  p_unsup_clean_r10: assert property (@(posedge clk) disable iff (!rstN)
    done && unsupported |-> !taken && cycles == 3'd0);

  // R11: a start during busy does not restart the count
  p_busy_continues_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !memWe |=> $stable(spOut));
endmodule

bind branch_unit branch_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .taken(taken), .unsupported(unsupported), .cycles(cycles),
  .spOut(spOut), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/branch_unit_tb.sv
module branch_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  rel = '0;
  logic [15:0] pcIn = '0;
  logic [15:0] spIn = '0;
  logic [5:0]  ccr = '0;
  logic        irqPin = 1'b0;
  logic        busy, done, taken, unsupported, memWe;
  logic [2:0]  cycles;
  logic [15:0] pcOut, spOut, memAddr;
  logic [7:0]  memData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  branch_unit u_dut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // returns {supported, subroutine, taken}
  function automatic logic [2:0] refModel(input logic [7:0] op,
                                          input logic [5:0] f, input logic pin);
    logic c, z, n, i, v;
    c = f[0]; z = f[1]; n = f[2]; i = f[3]; v = f[5];
    case (op)
      8'h20: return 3'b101;
      8'h21: return 3'b100;
      8'h23: return {2'b10, c | z};
      8'h24: return {2'b10, ~c};
      8'h25: return {2'b10, c};
      8'h26: return {2'b10, ~z};
      8'h2A: return {2'b10, ~n};
      8'h2B: return {2'b10, n};
      8'h2C: return {2'b10, ~i};
      8'h2D: return {2'b10, i};
      8'h2E: return {2'b10, ~pin};
      8'h2F: return {2'b10, pin};
      8'h91: return {2'b10, n ^ v};
      8'h93: return {2'b10, z | (n ^ v)};
      8'hAD: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  // pinSeen: pin level the synchroniser presents at the start edge
  task automatic runOp(input logic [7:0] op, input logic [7:0] r,
                       input logic [15:0] pc, input logic [15:0] sp,
                       input logic [5:0] f, input logic pinSeen, input bit disturb);
    logic [2:0]  exp;
    logic [15:0] ret, expPc;
    int nCyc, nWr, expCyc;
    logic [15:0] wa[2];
    logic [7:0]  wd[2];
    exp = refModel(op, f, pinSeen);
    ret = pc + 16'd2;
    expPc = !exp[2] ? pc : (exp[0] ? ret + {{8{r[7]}}, r} : ret);
    expCyc = !exp[2] ? 1 : (exp[1] ? 4 : 3);
    opcode = op; rel = r; pcIn = pc; spIn = sp; ccr = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nCyc = 1; nWr = 0;
    while (!done && nCyc < 20) begin
      if (memWe) begin
        if (nWr < 2) begin wa[nWr] = memAddr; wd[nWr] = memData; end
        nWr++;
      end
      if (disturb && nCyc == 1) begin
        start = 1'b1; opcode = 8'h20; rel = 8'h40; pcIn = 16'h5555; spIn = 16'h0100;
      end else start = 1'b0;
      @(negedge clk);
      nCyc++;
    end
    start = 1'b0;
    check(done, "R8", "done seen", done, 1);
    check(nCyc == expCyc, exp[2] ? (exp[1] ? "R9" : "R8") : "R10", "cycles to done", nCyc, expCyc);
    check(pcOut == expPc, exp[0] ? "R2 taken" : "R2 not-taken", "pcOut", pcOut, expPc);
    check(taken == exp[0], op == 8'h2E || op == 8'h2F ? "R6" : "R3/R4/R5/R7", "taken", taken, exp[0]);
    check(unsupported == !exp[2], "R10", "unsupported", unsupported, !exp[2]);
    check(cycles == (exp[2] ? (exp[1] ? 3'd4 : 3'd3) : 3'd0), "R8", "cycles port", cycles,
          exp[2] ? (exp[1] ? 4 : 3) : 0);
    if (exp[1]) begin
      check(nWr == 2, "R9", "write count", nWr, 2);
      if (nWr == 2) begin
        check(wa[0] == sp && wd[0] == ret[7:0], "R9", "low byte write", {wa[0], wd[0]}, {sp, ret[7:0]});
        check(wa[1] == sp - 16'd1 && wd[1] == ret[15:8], "R9", "high byte write",
              {wa[1], wd[1]}, {sp - 16'd1, ret[15:8]});
      end
      check(spOut == sp - 16'd2, disturb ? "R11" : "R9", "spOut", spOut, sp - 16'd2);
    end else begin
      check(nWr == 0, exp[2] ? "R8" : "R10", "no writes", nWr, 0);
    end
    @(negedge clk);
  endtask

  localparam logic [7:0] OPS [16] = '{8'h20, 8'h21, 8'h23, 8'h24, 8'h25, 8'h26, 8'h2A, 8'h2B,
                                     8'h2C, 8'h2D, 8'h2E, 8'h2F, 8'h91, 8'h93, 8'hAD, 8'h22};

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !memWe && pcOut == 0 && spOut == 0, "R1", "reset outputs",
          {busy, done, memWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memWe, "R1", "after reset", {busy, done, memWe}, 0);

    // directed corners
    runOp(8'h20, 8'h80, 16'h0010, 16'h00FF, 6'h00, 1'b0, 0); // R3 backward wrap below 0
    runOp(8'h21, 8'h7F, 16'h1234, 16'h00FF, 6'h3F, 1'b0, 0); // R3 never
    runOp(8'h20, 8'h7F, 16'hFFF0, 16'h00FF, 6'h00, 1'b0, 0); // R2 forward wrap
    runOp(8'h91, 8'h10, 16'h2000, 16'h00FF, 6'h20, 1'b0, 0); // R7 V only
    runOp(8'h93, 8'h10, 16'h2000, 16'h00FF, 6'h24, 1'b0, 0); // R7 N=V, Z=0
    runOp(8'hAD, 8'hF0, 16'h80FE, 16'h0100, 6'h00, 1'b0, 1); // R9 + R11 disturb
    runOp(8'h9D, 8'h22, 16'h4444, 16'h00FF, 6'h00, 1'b0, 0); // R10

    // R6: synchroniser latency
    irqPin = 1'b0; repeat (3) @(negedge clk);
    irqPin = 1'b1;
    runOp(8'h2F, 8'h08, 16'h3000, 16'h00FF, 6'h00, 1'b0, 0);
    irqPin = 1'b0; repeat (3) @(negedge clk);
    irqPin = 1'b1; @(negedge clk);
    runOp(8'h2F, 8'h08, 16'h3000, 16'h00FF, 6'h00, 1'b0, 0);
    irqPin = 1'b0; repeat (3) @(negedge clk);
    irqPin = 1'b1; repeat (2) @(negedge clk);
    runOp(8'h2F, 8'h08, 16'h3000, 16'h00FF, 6'h00, 1'b1, 0);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [7:0] op;
      logic pin;
      op = ($urandom % 8 == 0) ? 8'($urandom) : OPS[$urandom % 16];
      pin = 1'($urandom);
      irqPin = pin;
      repeat (3) @(negedge clk);
      runOp(op, 8'($urandom), 16'($urandom), 16'($urandom % 16'hFF00) + 16'h0010,
            6'($urandom), pin, ($urandom % 10) == 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule